// File: doc/BRIEF.md
# RGB Panel Timing Generator

This block produces the raster timing for a parallel RGB panel: horizontal sync, vertical sync, a data-enable strobe, and the column and row of the current active pixel. The host programs the sync widths, the back and front porches and the active size on each axis through a small write/read register port. Every field holds its true count minus one. A pixel-clock enable comes from a programmable divider of the source clock, and the divider can be bypassed so that the block advances on every cycle.

Each line runs sync, back porch, active region, front porch, counted in pixel ticks. Each frame follows the same order, counted in lines. A separate register inverts the output level of each strobe. At the start of every vertical sync the block raises a sticky frame flag, which can drive an interrupt line and which the host clears by writing a one to it. While output is switched off, both counters are held at the start of the frame and all three strobes stay at their inactive level.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset every register reads 0, hsync, vsync, de and frameIrq are 0, and pixX and pixY are 0.
- R2: While run (address 0 bit 0) is 0, both counters are held at line 0 pixel 0. Each strobe stays at its inactive level, which equals its polarity bit. pixX and pixY are 0. Setting run again restarts at line 0 pixel 0.
- R3: A line lasts (HS+1)+(HB+1)+(HA+1)+(HF+1) pixel ticks. hsync is active for the first HS+1 of them. The fields are HS = address 2 [7:0], HB = address 2 [15:8], HF = address 2 [23:16] and HA = address 4 [11:0].
- R4: A frame lasts (VS+1)+(VB+1)+(VA+1)+(VF+1) lines. vsync is active for the first VS+1 lines. The fields are VS, VB and VF at address 3 (same positions as at address 2) and VA = address 4 [27:16].
- R5: de is active only when both axes are inside their active regions. pixX and pixY give the offset inside the active region on their own axis, and each reads 0 while its axis is outside that region.
- R6: With address 0 bit 1 set, a pixel tick occurs once every D+1 source cycles, where D = address 0 [15:8]. The first tick comes D+1 cycles after run is set.
- R7: With address 0 bit 1 clear, a pixel tick occurs on every source cycle, whatever value D holds.
- R8: Address 1 bit 0, bit 1 and bit 2 invert hsync, vsync and de respectively. A strobe whose bit is 1 is active low.
- R9: The pending flag (address 5 bit 1) is set on the clock edge where the counters wrap from the last tick of a frame to the first tick of vertical sync. frameIrq equals pending AND the interrupt enable (address 5 bit 0).
- R10: Writing address 5 with bit 1 set clears pending, and writing bit 1 as 0 leaves it unchanged. If a clear and a frame wrap fall on the same edge, the flag ends up set.
- R11: Every register reads back its writable fields at the positions given above, with all other bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pixX | output | SIZE_W | Active column |
| pixY | output | SIZE_W | Active row |
| frameIrq | output | 1 | Frame interrupt |

## Verification
The bench runs several full frames with small, deliberately unequal porch and sync settings, so that an off-by-one in any stored-minus-one field moves an edge by a visible tick. A design that left out the +1 on any one field would shift hsync, de or the coordinates on some sample. The divided case checks that the first tick comes D+1 cycles after enable. A divider off by one cycle would stretch or shrink every pixel, and a bypass that still honoured D would slow the bypassed sweep. The bench also checks the exact edge at which pending sets, that writing zero to pending leaves it set, and that disabling output mid-frame snaps all strobes to their polarity-defined idle levels. A design that got any of these wrong would fire a frame early or late, lose the flag, or leave a sync asserted.

// File: rtl/lcdtg_pkg.sv
package lcdtg_pkg;
  typedef enum logic [2:0] {
    ADDR_CTRL = 3'd0,
    ADDR_POL  = 3'd1,
    ADDR_HTIM = 3'd2,
    ADDR_VTIM = 3'd3,
    ADDR_SIZE = 3'd4,
    ADDR_INT  = 3'd5
  } regSel_e;

  typedef struct packed {
    logic run;
    logic tick;
  } strobe_t;
endpackage

// File: rtl/lcdtg_axis.sv
module lcdtg_axis #(
  parameter int PORCH_W = 8,
  parameter int SIZE_W  = 12,
  parameter int CNT_W   = SIZE_W + 2
) (
  input  logic [CNT_W-1:0]   cnt,
  input  logic [PORCH_W-1:0] syncM1,
  input  logic [PORCH_W-1:0] backM1,
  input  logic [SIZE_W-1:0]  actM1,
  input  logic [PORCH_W-1:0] frontM1,
  output logic               inSync,
  output logic               inAct,
  output logic               atLast,
  output logic [SIZE_W-1:0]  coord
);
  logic [CNT_W-1:0] syncEnd, actStart, actEnd, lastIdx, offset;

  always_comb begin
    syncEnd  = CNT_W'(syncM1) + CNT_W'(1);
    actStart = syncEnd + CNT_W'(backM1) + CNT_W'(1);
    actEnd   = actStart + CNT_W'(actM1) + CNT_W'(1);
    lastIdx  = actEnd + CNT_W'(frontM1);
    inSync   = cnt < syncEnd;
    inAct    = (cnt >= actStart) && (cnt < actEnd);
    atLast   = cnt >= lastIdx;
    offset   = cnt - actStart;
    coord    = inAct ? offset[SIZE_W-1:0] : '0;
  end
endmodule

// File: rtl/lcdtg_datapath.sv
module lcdtg_datapath
  import lcdtg_pkg::*;
#(
  parameter int PORCH_W = 8,
  parameter int SIZE_W  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [PORCH_W-1:0] hSyncM1,
  input  logic [PORCH_W-1:0] hBackM1,
  input  logic [PORCH_W-1:0] hFrontM1,
  input  logic [SIZE_W-1:0]  hActM1,
  input  logic [PORCH_W-1:0] vSyncM1,
  input  logic [PORCH_W-1:0] vBackM1,
  input  logic [PORCH_W-1:0] vFrontM1,
  input  logic [SIZE_W-1:0]  vActM1,
  input  logic [2:0]         pol,
  output logic               hsync,
  output logic               vsync,
  output logic               de,
  output logic [SIZE_W-1:0]  pixX,
  output logic [SIZE_W-1:0]  pixY,
  output logic               frameEvt
);
  localparam int CNT_W = SIZE_W + 2;
  localparam int AXES  = 2;

  logic [CNT_W-1:0]   cnt     [AXES];
  logic [PORCH_W-1:0] syncSel [AXES];
  logic [PORCH_W-1:0] backSel [AXES];
  logic [PORCH_W-1:0] frontSel[AXES];
  logic [SIZE_W-1:0]  actSel  [AXES];
  logic [SIZE_W-1:0]  coord   [AXES];
  logic [AXES-1:0]    inSync, inAct, atLast;

  assign syncSel[0]  = hSyncM1;
  assign backSel[0]  = hBackM1;
  assign frontSel[0] = hFrontM1;
  assign actSel[0]   = hActM1;
  assign syncSel[1]  = vSyncM1;
  assign backSel[1]  = vBackM1;
  assign frontSel[1] = vFrontM1;
  assign actSel[1]   = vActM1;

  for (genvar a = 0; a < AXES; a++) begin : gAxis
    lcdtg_axis #(.PORCH_W(PORCH_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W)) axis (
      .cnt    (cnt[a]),
      .syncM1 (syncSel[a]),
      .backM1 (backSel[a]),
      .actM1  (actSel[a]),
      .frontM1(frontSel[a]),
      .inSync (inSync[a]),
      .inAct  (inAct[a]),
      .atLast (atLast[a]),
      .coord  (coord[a])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strb.run) begin
      cnt[0] <= '0;
      cnt[1] <= '0;
    end else if (strb.tick) begin
      if (atLast[0]) begin
        cnt[0] <= '0;
        cnt[1] <= atLast[1] ? '0 : cnt[1] + CNT_W'(1);
      end else begin
        cnt[0] <= cnt[0] + CNT_W'(1);
      end
    end
  end

  always_comb begin
    frameEvt = strb.tick && atLast[0] && atLast[1];
    hsync    = (strb.run && inSync[0]) ^ pol[0];
    vsync    = (strb.run && inSync[1]) ^ pol[1];
    de       = (strb.run && inAct[0] && inAct[1]) ^ pol[2];
    pixX     = strb.run ? coord[0] : '0;
    pixY     = strb.run ? coord[1] : '0;
  end
endmodule

// File: rtl/lcdtg_ctrl.sv
module lcdtg_ctrl
  import lcdtg_pkg::*;
#(
  parameter int PORCH_W = 8,
  parameter int SIZE_W  = 12,
  parameter int DIV_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [2:0]         regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  logic               frameEvt,
  output strobe_t            strb,
  output logic [PORCH_W-1:0] hSyncM1,
  output logic [PORCH_W-1:0] hBackM1,
  output logic [PORCH_W-1:0] hFrontM1,
  output logic [SIZE_W-1:0]  hActM1,
  output logic [PORCH_W-1:0] vSyncM1,
  output logic [PORCH_W-1:0] vBackM1,
  output logic [PORCH_W-1:0] vFrontM1,
  output logic [SIZE_W-1:0]  vActM1,
  output logic [2:0]         pol,
  output logic               pending,
  output logic               frameIrq
);
  localparam int BACK_LSB  = PORCH_W;
  localparam int FRONT_LSB = 2 * PORCH_W;
  localparam int DIV_LSB   = 8;
  localparam int VACT_LSB  = 16;

  logic             runEn, divSel, intEn;
  logic [DIV_W-1:0] divM1, divCnt;
  logic             wrInt;

  assign wrInt = regWe && (regAddr == ADDR_INT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runEn <= 1'b0; divSel <= 1'b0; divM1 <= '0; pol <= '0; intEn <= 1'b0;
      hSyncM1 <= '0; hBackM1 <= '0; hFrontM1 <= '0; hActM1 <= '0;
      vSyncM1 <= '0; vBackM1 <= '0; vFrontM1 <= '0; vActM1 <= '0;
    end else if (regWe) begin
      case (regAddr)
        ADDR_CTRL: begin
          runEn  <= regWrData[0];
          divSel <= regWrData[1];
          divM1  <= regWrData[DIV_LSB +: DIV_W];
        end
        ADDR_POL: pol <= regWrData[2:0];
        ADDR_HTIM: begin
          hSyncM1  <= regWrData[0 +: PORCH_W];
          hBackM1  <= regWrData[BACK_LSB +: PORCH_W];
          hFrontM1 <= regWrData[FRONT_LSB +: PORCH_W];
        end
        ADDR_VTIM: begin
          vSyncM1  <= regWrData[0 +: PORCH_W];
          vBackM1  <= regWrData[BACK_LSB +: PORCH_W];
          vFrontM1 <= regWrData[FRONT_LSB +: PORCH_W];
        end
        ADDR_SIZE: begin
          hActM1 <= regWrData[0 +: SIZE_W];
          vActM1 <= regWrData[VACT_LSB +: SIZE_W];
        end
        ADDR_INT: intEn <= regWrData[0];
        default: ;
      endcase
    end
  end

  // frame wrap takes precedence over a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rstN)                         pending <= 1'b0;
    else if (frameEvt)                 pending <= 1'b1;
    else if (wrInt && regWrData[1])    pending <= 1'b0;
  end

  always_comb begin
    strb.run  = runEn;
    strb.tick = runEn && (!divSel || (divCnt == divM1));
  end

  always_ff @(posedge clk) begin
    if (!rstN || !runEn)  divCnt <= '0;
    else if (strb.tick)   divCnt <= '0;
    else                  divCnt <= divCnt + DIV_W'(1);
  end

  assign frameIrq = pending && intEn;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CTRL: begin
        regRdData[0] = runEn;
        regRdData[1] = divSel;
        regRdData[DIV_LSB +: DIV_W] = divM1;
      end
      ADDR_POL: regRdData[2:0] = pol;
      ADDR_HTIM: begin
        regRdData[0 +: PORCH_W]         = hSyncM1;
        regRdData[BACK_LSB +: PORCH_W]  = hBackM1;
        regRdData[FRONT_LSB +: PORCH_W] = hFrontM1;
      end
      ADDR_VTIM: begin
        regRdData[0 +: PORCH_W]         = vSyncM1;
        regRdData[BACK_LSB +: PORCH_W]  = vBackM1;
        regRdData[FRONT_LSB +: PORCH_W] = vFrontM1;
      end
      ADDR_SIZE: begin
        regRdData[0 +: SIZE_W]        = hActM1;
        regRdData[VACT_LSB +: SIZE_W] = vActM1;
      end
      ADDR_INT: regRdData[1:0] = {pending, intEn};
      default: ;
    endcase
  end
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcdtg_pkg::*;
#(
  parameter int PORCH_W = 8,
  parameter int SIZE_W  = 12,
  parameter int DIV_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [SIZE_W-1:0] pixX,
  output logic [SIZE_W-1:0] pixY,
  output logic              frameIrq
);
  strobe_t            strb;
  logic               frameEvt, pending;
  logic [2:0]         pol;
  logic [PORCH_W-1:0] hSyncM1, hBackM1, hFrontM1, vSyncM1, vBackM1, vFrontM1;
  logic [SIZE_W-1:0]  hActM1, vActM1;

  lcdtg_ctrl #(.PORCH_W(PORCH_W), .SIZE_W(SIZE_W), .DIV_W(DIV_W)) ctrl (
    .clk, .rstN, .regWe, .regAddr, .regWrData, .regRdData,
    .frameEvt, .strb,
    .hSyncM1, .hBackM1, .hFrontM1, .hActM1,
    .vSyncM1, .vBackM1, .vFrontM1, .vActM1,
    .pol, .pending, .frameIrq
  );

  lcdtg_datapath #(.PORCH_W(PORCH_W), .SIZE_W(SIZE_W)) dp (
    .clk, .rstN, .strb,
    .hSyncM1, .hBackM1, .hFrontM1, .hActM1,
    .vSyncM1, .vBackM1, .vFrontM1, .vActM1,
    .pol, .hsync, .vsync, .de, .pixX, .pixY, .frameEvt
  );
endmodule

// File: rtl/lcdtg_checker.sv
module lcdtg_checker
  import lcdtg_pkg::*;
#(
  parameter int SIZE_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [2:0]        regAddr,
  input logic [31:0]       regWrData,
  input logic              hsync,
  input logic              vsync,
  input logic              de,
  input logic [SIZE_W-1:0] pixX,
  input logic [SIZE_W-1:0] pixY,
  input logic [2:0]        pol,
  input strobe_t           strb,
  input logic              frameEvt,
  input logic              pending
);
  assert_de_outside_hsync_R5: assert property (@(posedge clk) disable iff (!rstN)
    (de != pol[2]) |-> (hsync == pol[0]));

  assert_idle_when_stopped_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |-> (hsync == pol[0] && vsync == pol[1] && de == pol[2]
                   && pixX == '0 && pixY == '0));

  assert_hold_between_ticks_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.tick && !regWe) |=>
      ($stable(pixX) && $stable(pixY) && $stable(hsync) && $stable(vsync) && $stable(de)));

  assert_pending_from_wrap_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pending) |-> $past(frameEvt));

  assert_write_one_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_INT && regWrData[1] && !frameEvt) |=> !pending);
endmodule

bind lcd_timing_gen lcdtg_checker #(.SIZE_W(SIZE_W)) chk (
  .clk, .rstN, .regWe, .regAddr, .regWrData,
  .hsync, .vsync, .de, .pixX, .pixY,
  .pol, .strb, .frameEvt, .pending
);

// File: tb/lcd_timing_gen_test.sv
`timescale 1ns/1ps
module lcd_timing_gen_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        hsync, vsync, de, frameIrq;
  logic [11:0] pixX, pixY;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  lcd_timing_gen uut (
    .clk, .rstN, .regWe, .regAddr, .regWrData, .regRdData,
    .hsync, .vsync, .de, .pixX, .pixY, .frameIrq
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] outVec();
    return {4'b0, hsync, vsync, de, frameIrq, pixX, pixY};
  endfunction

  task automatic wr(logic [2:0] a, logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk);
    @(negedge clk);
    regWe = 1'b0; regWrData = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic sweep(string tag, int hs, int hb, int ha, int hf,
                       int vs, int vb, int va, int vf,
                       bit divSel, int divField, logic [2:0] pol, int cycles);
    int n, ht, vt, fr;
    n  = divSel ? divField + 1 : 1;
    ht = hs + hb + ha + hf;
    vt = vs + vb + va + vf;
    fr = ht * vt;
    wr(3'd0, 32'h0);
    wr(3'd2, {8'h0, 8'(hf-1), 8'(hb-1), 8'(hs-1)});
    wr(3'd3, {8'h0, 8'(vf-1), 8'(vb-1), 8'(vs-1)});
    wr(3'd4, {4'h0, 12'(va-1), 4'h0, 12'(ha-1)});
    wr(3'd1, {29'h0, pol});
    wr(3'd5, 32'h3);
    wr(3'd0, {16'h0, 8'(divField), 6'h0, divSel, 1'b1});
    for (int m = 0; m < cycles; m++) begin
      int t, p, h, v;
      bit hA, vA;
      logic [31:0] exp;
      t  = m / n;
      p  = t % fr;
      h  = p % ht;
      v  = p / ht;
      hA = (h >= hs + hb) && (h < hs + hb + ha);
      vA = (v >= vs + vb) && (v < vs + vb + va);
      exp = {4'b0, (h < hs) ^ pol[0], (v < vs) ^ pol[1], (hA && vA) ^ pol[2],
             t >= fr, hA ? 12'(h - hs - hb) : 12'h0, vA ? 12'(v - vs - vb) : 12'h0};
      check(tag, outVec(), exp);
      @(negedge clk);
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 outputs", outVec(), 32'h0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      check("R1 register", d, 32'h0);
    end

    // R11 readback with output off
    wr(3'd2, 32'hFFABCDEF); rd(3'd2, d); check("R11 htim", d, 32'h00ABCDEF);
    wr(3'd3, 32'h12345678); rd(3'd3, d); check("R11 vtim", d, 32'h00345678);
    wr(3'd4, 32'hFFFFFFFF); rd(3'd4, d); check("R11 size", d, 32'h0FFF0FFF);
    wr(3'd0, 32'hFFFFFFFE); rd(3'd0, d); check("R11 ctrl", d, 32'h0000FF02);
    wr(3'd1, 32'hFFFFFFFF); rd(3'd1, d); check("R11 pol", d, 32'h00000007);

    // R2 R8 idle levels while stopped with all polarities inverted
    repeat (3) begin
      @(negedge clk);
      check("R2 R8 idle inverted", outVec(), {4'b0, 4'b1110, 24'h0});
    end

    // R3 R4 R5 R7 R9 bypass: divider field ignored
    sweep("R3 R4 R5 R7 R9 bypass", 1, 2, 4, 1, 1, 1, 3, 2, 1'b0, 5, 3'b000, 130);

    // R3 R4 R5 R6 R8 R9 divide by three, all inverted
    sweep("R3 R4 R5 R6 R8 R9 div3", 2, 1, 3, 2, 2, 1, 2, 1, 1'b1, 2, 3'b111, 170);

    // R6 divided select with ratio one, vsync only inverted
    sweep("R3 R4 R6 R8 div1", 3, 1, 2, 3, 1, 2, 2, 1, 1'b1, 0, 3'b010, 70);

    // R2 stop mid-frame: strobes snap to idle
    wr(3'd0, 32'h0);
    repeat (4) begin
      check("R2 stopped", {outVec()} & 32'hFE00_0000 | {4'b0, hsync, vsync, de, 1'b0, pixX, pixY},
            {4'b0, 3'b010, 1'b0, 24'h0});
      @(negedge clk);
    end

    // R9 pending survives with interrupt line masked
    wr(3'd5, 32'h0);
    check("R9 masked irq", {31'h0, frameIrq}, 32'h0);
    rd(3'd5, d); check("R9 pending held", d, 32'h2);

    // R10 writing zero to pending leaves it
    wr(3'd5, 32'h1);
    check("R10 zero write keeps", {31'h0, frameIrq}, 32'h1);
    rd(3'd5, d); check("R10 zero write keeps reg", d, 32'h3);
    wr(3'd5, 32'h3);
    check("R10 one clears", {31'h0, frameIrq}, 32'h0);
    rd(3'd5, d); check("R10 one clears reg", d, 32'h1);

    // R2 restart from line 0 pixel 0 after re-enable
    wr(3'd1, 32'h0);
    wr(3'd0, 32'h1);
    check("R2 restart", outVec(), {4'b0, 4'b1100, 24'h0});

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule